// File: doc/BRIEF.md
# Bus Master Termination Controller

This block decides how a transaction that the bridge starts as an initiator on a parallel bus comes to an end. Once the address phase begins, it waits a fixed number of clocks for a target to claim the cycle. It then follows the target's ready and stop replies through the data phases and classifies the ending as one of eight kinds. It raises one-cycle strobes for the received-abort status bits and for error completions of reads. When a transaction must be started again, it asks for that with the length that is still left to move. Data buffering, parity and bus arbitration are handled elsewhere: here the length is only counted, and a data phase completes when claim and target-ready are seen together.

The controller has four states. S_IDLE accepts a new transaction on `txn_start` and goes to S_SELWAIT. S_SELWAIT counts the clocks of the claim window. A claim moves it to S_DATA, or ends the transaction at once when the phase in that same cycle already decides the ending. An empty window ends the transaction with an abort and returns to S_IDLE. S_DATA evaluates every data phase. A retry moves it to S_BACKOFF, and every other ending returns to S_IDLE. S_BACKOFF waits out the back-off period, then asks for the re-issue and returns to S_IDLE. All outputs are registered and appear one clock after the edge that makes the decision.

Top module: `pci_master_term`

## Requirements
- R1: While `rst_n` is low, and after reset until a transaction ends, every output is zero.
- R2: A claim (`devsel`) seen on any of the five clocks that follow the clock on which `txn_start` is accepted lets the transaction go on. If no claim is seen on those five clocks, the transaction ends as a master abort. That ending is reported on the clock after the fifth.
- R3: A master abort of an ordinary transaction pulses `set_mabort`, and also pulses `cpl_err` when the transaction is a read (`txn_read`=1). A master abort of a write leaves `cpl_err` low.
- R4: For a special-cycle transaction (`txn_special`=1), an empty claim window ends with the special-end kind and leaves `set_mabort` and `cpl_err` low. If a target does claim it, the transaction ends as a burst disconnect right after the first data transfer.
- R5: `stop` with no claim during the data state ends the transaction as a target abort and pulses `set_tabort`, plus `cpl_err` for reads. `term_xfer` gives the words moved before the abort, and `term_rem` gives the words that receive the error status.
- R6: `stop` from the target ends the transaction as a target disconnect. This holds when `trdy` is also high (the word moves) and when no word has moved yet in a phase after the first transfer. `reissue_req` pulses together with `term_valid`, and `reissue_len` gives the remaining length.
- R7: `stop` without `trdy` before any word has moved ends the transaction as a retry. `reissue_req` with the full length pulses exactly two clocks after the retry is reported, never earlier. This repeats for every retry with no limit.
- R8: When a word moves while `lat_expired` is high and `gnt` is low, the transaction ends with the latency kind and a re-issue of the remainder. `lat_expired` has no effect while `gnt` is high.
- R9: In conventional mode (`conv_mode`=1), a transaction whose two low address bits are not zero ends as a burst disconnect after its first transfer and pulses `burst_disc`. With aligned address bits, or with `conv_mode`=0, the burst goes on.
- R10: The transfer of the last word always ends the transaction normally, with `term_rem`=0 and no re-issue, even when `stop`, or a latency expiry with the grant removed, comes in the same clock.
- R11: `txn_start` is ignored while a transaction or its back-off is in progress. A start during back-off does not change the length that is re-issued.
- R12: `term_kind` codes: 0 normal, 1 master abort, 2 special end, 3 target abort, 4 retry, 5 target disconnect, 6 burst disconnect, 7 latency end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| txn_start | input | 1 | First clock of the address phase of a new transaction |
| txn_len | input | LEN_W | Words to move, at least 1 |
| txn_read | input | 1 | Transaction is a read |
| txn_special | input | 1 | Special cycle translated from a configuration request |
| addr_lo | input | 2 | Two low address bits |
| conv_mode | input | 1 | Bus runs in conventional (not extended) mode |
| devsel | input | 1 | Target claims the cycle (active high) |
| trdy | input | 1 | Target ready (active high) |
| stop | input | 1 | Target asks the initiator to stop (active high) |
| gnt | input | 1 | Bus grant still held |
| lat_expired | input | 1 | Latency timer has run out |
| term_valid | output | 1 | One-cycle pulse: a transaction has ended |
| term_kind | output | 3 | Ending kind, codes in R12 |
| term_xfer | output | LEN_W | Words moved in the ended transaction |
| term_rem | output | LEN_W | Words left at the ending |
| set_mabort | output | 1 | Set strobe for the received-master-abort bit |
| set_tabort | output | 1 | Set strobe for the received-target-abort bit |
| cpl_err | output | 1 | A read completes upstream with error status |
| reissue_req | output | 1 | One-cycle request to start the transaction again |
| reissue_len | output | LEN_W | Length for the re-issue, valid with reissue_req |
| burst_disc | output | 1 | Initiator chose to disconnect after the first transfer |

## Verification
Several endings can fall in the same cycle as a word transfer: the last word arriving with `stop`, or with an expired latency timer while the grant is removed. The bench drives these on purpose. A completion must win over a disconnect or a latency end, and a disconnect with data must count the word that moved. A second overlap is a new start that arrives during the retry back-off. The bench judges each of these against a behavioural model that it compares on every clock, so the ending kind, both counts and the re-issue length are checked in the exact cycle they appear.

// File: rtl/mt_pkg.sv
package mt_pkg;

    typedef enum logic [2:0] {
        TK_NORMAL  = 3'd0,
        TK_MABORT  = 3'd1,
        TK_SPECIAL = 3'd2,
        TK_TABORT  = 3'd3,
        TK_RETRY   = 3'd4,
        TK_DISC    = 3'd5,
        TK_BURST   = 3'd6,
        TK_LATENCY = 3'd7
    } term_kind_e;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_SELWAIT = 2'd1,
        S_DATA    = 2'd2,
        S_BACKOFF = 2'd3
    } mt_state_e;

    typedef struct packed {
        logic       hit;
        logic       xfer;
        term_kind_e kind;
    } phase_verdict_t;

endpackage

// File: rtl/mt_sel_window.sv
module mt_sel_window #(
    parameter int WINDOW = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int CW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (run && cnt != LAST) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign expired = run && (cnt == LAST);
endmodule

// File: rtl/mt_backoff.sv
module mt_backoff #(
    parameter int CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic done
);
    generate
        if (CLKS <= 1) begin : g_short
            assign done = run;
        end else begin : g_count
            localparam int CW = $clog2(CLKS);
            localparam logic [CW-1:0] LAST = CW'(CLKS - 1);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (load) begin
                    cnt <= '0;
                end else if (run && cnt != LAST) begin
                    cnt <= cnt + CW'(1);
                end
            end

            assign done = run && (cnt == LAST);
        end
    endgenerate
endmodule

// File: rtl/mt_classify.sv
module mt_classify
    import mt_pkg::*;
(
    input  logic           devsel,
    input  logic           trdy,
    input  logic           stop,
    input  logic           first,
    input  logic           last,
    input  logic           special,
    input  logic           unaligned,
    input  logic           lat_expired,
    input  logic           gnt,
    output phase_verdict_t verdict
);
    always_comb begin
        verdict = '{hit: 1'b0, xfer: 1'b0, kind: TK_NORMAL};
        if (!devsel) begin
            // Target let go of the claim and stops: target abort.
            if (stop) begin
                verdict.hit  = 1'b1;
                verdict.kind = TK_TABORT;
            end
        end else if (trdy) begin
            verdict.xfer = 1'b1;
            if (last) begin
                verdict.hit  = 1'b1;
                verdict.kind = TK_NORMAL;
            end else if (stop) begin
                verdict.hit  = 1'b1;
                verdict.kind = TK_DISC;
            end else if (first && (special || unaligned)) begin
                verdict.hit  = 1'b1;
                verdict.kind = TK_BURST;
            end else if (lat_expired && !gnt) begin
                verdict.hit  = 1'b1;
                verdict.kind = TK_LATENCY;
            end
        end else if (stop) begin
            verdict.hit  = 1'b1;
            verdict.kind = first ? TK_RETRY : TK_DISC;
        end
    end
endmodule

// File: rtl/pci_master_term.sv
module pci_master_term
    import mt_pkg::*;
#(
    parameter int LEN_W        = 8,
    parameter int SEL_WINDOW   = 5,
    parameter int BACKOFF_CLKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             txn_start,
    input  logic [LEN_W-1:0] txn_len,
    input  logic             txn_read,
    input  logic             txn_special,
    input  logic [1:0]       addr_lo,
    input  logic             conv_mode,
    input  logic             devsel,
    input  logic             trdy,
    input  logic             stop,
    input  logic             gnt,
    input  logic             lat_expired,
    output logic             term_valid,
    output logic [2:0]       term_kind,
    output logic [LEN_W-1:0] term_xfer,
    output logic [LEN_W-1:0] term_rem,
    output logic             set_mabort,
    output logic             set_tabort,
    output logic             cpl_err,
    output logic             reissue_req,
    output logic [LEN_W-1:0] reissue_len,
    output logic             burst_disc
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    mt_state_e      st, st_nx;
    logic [LEN_W-1:0] rem, rem_nx;
    logic [LEN_W-1:0] moved, moved_nx;
    logic           is_read, is_special, is_unaligned;

    logic           accept;
    logic           win_run, win_expired;
    logic           bo_load, bo_run, bo_done;
    phase_verdict_t verdict;

    logic           fin;
    term_kind_e     fin_kind;
    logic           go_reissue;
    logic [LEN_W-1:0] reissue_val;

    assign accept  = (st == S_IDLE) && txn_start;
    assign win_run = (st == S_SELWAIT) && !devsel;
    assign bo_run  = (st == S_BACKOFF);
    assign bo_load = fin && (fin_kind == TK_RETRY);

    mt_sel_window #(.WINDOW(SEL_WINDOW)) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .run     (win_run),
        .expired (win_expired)
    );

    mt_backoff #(.CLKS(BACKOFF_CLKS)) u_backoff (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (bo_load),
        .run   (bo_run),
        .done  (bo_done)
    );

    mt_classify u_classify (
        .devsel      (devsel),
        .trdy        (trdy),
        .stop        (stop),
        .first       (moved == '0),
        .last        (rem == ONE),
        .special     (is_special),
        .unaligned   (is_unaligned),
        .lat_expired (lat_expired),
        .gnt         (gnt),
        .verdict     (verdict)
    );

    // Next-state and ending decision.
    always_comb begin
        st_nx       = st;
        rem_nx      = rem;
        moved_nx    = moved;
        fin         = 1'b0;
        fin_kind    = TK_NORMAL;
        go_reissue  = 1'b0;
        reissue_val = rem;
        unique case (st)
            S_IDLE: begin
                if (txn_start) begin
                    st_nx = S_SELWAIT;
                end
            end
            S_SELWAIT, S_DATA: begin
                if (st == S_SELWAIT && !devsel) begin
                    if (win_expired) begin
                        fin      = 1'b1;
                        fin_kind = is_special ? TK_SPECIAL : TK_MABORT;
                        st_nx    = S_IDLE;
                    end
                end else begin
                    if (verdict.xfer) begin
                        rem_nx   = rem - ONE;
                        moved_nx = moved + ONE;
                    end
                    if (verdict.hit) begin
                        fin         = 1'b1;
                        fin_kind    = verdict.kind;
                        reissue_val = rem_nx;
                        if (verdict.kind == TK_RETRY) begin
                            st_nx = S_BACKOFF;
                        end else begin
                            st_nx = S_IDLE;
                        end
                        if (verdict.kind == TK_DISC || verdict.kind == TK_BURST ||
                            verdict.kind == TK_LATENCY) begin
                            go_reissue = 1'b1;
                        end
                    end else begin
                        st_nx = S_DATA;
                    end
                end
            end
            S_BACKOFF: begin
                if (bo_done) begin
                    go_reissue = 1'b1;
                    st_nx      = S_IDLE;
                end
            end
        endcase
    end

    // State and transaction context.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st           <= S_IDLE;
            rem          <= '0;
            moved        <= '0;
            is_read      <= 1'b0;
            is_special   <= 1'b0;
            is_unaligned <= 1'b0;
        end else begin
            st <= st_nx;
            if (accept) begin
                rem          <= txn_len;
                moved        <= '0;
                is_read      <= txn_read;
                is_special   <= txn_special;
                is_unaligned <= conv_mode && (addr_lo != 2'b00);
            end else begin
                rem   <= rem_nx;
                moved <= moved_nx;
            end
        end
    end

    // Registered outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            term_valid  <= 1'b0;
            term_kind   <= 3'd0;
            term_xfer   <= '0;
            term_rem    <= '0;
            set_mabort  <= 1'b0;
            set_tabort  <= 1'b0;
            cpl_err     <= 1'b0;
            reissue_req <= 1'b0;
            reissue_len <= '0;
            burst_disc  <= 1'b0;
        end else begin
            term_valid  <= fin;
            term_kind   <= fin ? fin_kind : TK_NORMAL;
            term_xfer   <= fin ? moved_nx : '0;
            term_rem    <= fin ? rem_nx : '0;
            set_mabort  <= fin && (fin_kind == TK_MABORT);
            set_tabort  <= fin && (fin_kind == TK_TABORT);
            cpl_err     <= fin && is_read &&
                           (fin_kind == TK_MABORT || fin_kind == TK_TABORT);
            reissue_req <= go_reissue;
            reissue_len <= go_reissue ? reissue_val : '0;
            burst_disc  <= fin && (fin_kind == TK_BURST);
        end
    end
endmodule

// File: rtl/mt_checker.sv
module mt_checker #(
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             term_valid,
    input logic [2:0]       term_kind,
    input logic [LEN_W-1:0] term_xfer,
    input logic [LEN_W-1:0] term_rem,
    input logic             set_mabort,
    input logic             set_tabort,
    input logic             cpl_err,
    input logic             reissue_req,
    input logic [LEN_W-1:0] reissue_len,
    input logic             burst_disc
);
    assert_mabort_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        set_mabort |-> (term_valid && term_kind == 3'd1));

    assert_special_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (term_valid && term_kind == 3'd2) |-> (!set_mabort && !cpl_err));

    assert_tabort_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        set_tabort |-> (term_valid && term_kind == 3'd3));

    assert_reissue_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reissue_req |-> (reissue_len != '0));

    assert_retry_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (term_valid && term_kind == 3'd4) |=> !reissue_req);

    assert_retry_no_reissue_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (term_valid && term_kind == 3'd4) |-> !reissue_req);

    assert_burst_one_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
        burst_disc |-> (term_valid && term_xfer == LEN_W'(1)));

    assert_normal_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (term_valid && term_kind == 3'd0) |-> (term_rem == '0 && !reissue_req));

    assert_one_status_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({set_mabort, set_tabort, burst_disc}));
endmodule

bind pci_master_term mt_checker #(.LEN_W(LEN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .term_valid  (term_valid),
    .term_kind   (term_kind),
    .term_xfer   (term_xfer),
    .term_rem    (term_rem),
    .set_mabort  (set_mabort),
    .set_tabort  (set_tabort),
    .cpl_err     (cpl_err),
    .reissue_req (reissue_req),
    .reissue_len (reissue_len),
    .burst_disc  (burst_disc)
);

// File: tb/pci_master_term_tb.sv
`timescale 1ns/1ps
module pci_master_term_tb;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          txn_start = 1'b0;
    logic [LW-1:0] txn_len = '0;
    logic          txn_read = 1'b0, txn_special = 1'b0, conv_mode = 1'b0;
    logic [1:0]    addr_lo = 2'b00;
    logic          devsel = 1'b0, trdy = 1'b0, stop = 1'b0;
    logic          gnt = 1'b1, lat_expired = 1'b0;

    logic          term_valid, set_mabort, set_tabort, cpl_err, reissue_req, burst_disc;
    logic [2:0]    term_kind;
    logic [LW-1:0] term_xfer, term_rem, reissue_len;

    int nchk = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    pci_master_term u_dut (
        .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_len(txn_len),
        .txn_read(txn_read), .txn_special(txn_special), .addr_lo(addr_lo),
        .conv_mode(conv_mode), .devsel(devsel), .trdy(trdy), .stop(stop),
        .gnt(gnt), .lat_expired(lat_expired), .term_valid(term_valid),
        .term_kind(term_kind), .term_xfer(term_xfer), .term_rem(term_rem),
        .set_mabort(set_mabort), .set_tabort(set_tabort), .cpl_err(cpl_err),
        .reissue_req(reissue_req), .reissue_len(reissue_len), .burst_disc(burst_disc)
    );

    // Behavioural reference: phase 0 idle, 1 claim wait, 2 data, 3 back-off.
    int m_phase = 0, m_wait = 0, m_bo = 0, m_rem = 0, m_moved = 0;
    bit m_read = 0, m_spec = 0, m_unal = 0;
    int e_valid, e_kind, e_xfer, e_rem, e_mab, e_tab, e_cpl, e_reis, e_rlen, e_burst;

    task automatic m_end(input int k);
        e_valid = 1; e_kind = k; e_xfer = m_moved; e_rem = m_rem;
        e_mab   = (k == 1) ? 1 : 0;
        e_tab   = (k == 3) ? 1 : 0;
        e_cpl   = (m_read && (k == 1 || k == 3)) ? 1 : 0;
        e_burst = (k == 6) ? 1 : 0;
        if (k == 5 || k == 6 || k == 7) begin e_reis = 1; e_rlen = m_rem; end
        if (k == 4) begin m_phase = 3; m_bo = 0; end
        else m_phase = 0;
    endtask

    task automatic m_phase_eval();
        bit moved_word;
        moved_word = devsel && trdy;
        if (moved_word) begin m_rem = m_rem - 1; m_moved = m_moved + 1; end
        if (!devsel && stop) m_end(3);
        else if (moved_word && m_rem == 0) m_end(0);
        else if (moved_word && stop) m_end(5);
        else if (moved_word && m_moved == 1 && (m_spec || m_unal)) m_end(6);
        else if (moved_word && lat_expired && !gnt) m_end(7);
        else if (devsel && stop) m_end(m_moved == 0 ? 4 : 5);
        else m_phase = 2;
    endtask

    always @(posedge clk) begin
        e_valid = 0; e_kind = 0; e_xfer = 0; e_rem = 0; e_mab = 0;
        e_tab = 0; e_cpl = 0; e_reis = 0; e_rlen = 0; e_burst = 0;
        if (!rst_n) begin
            m_phase = 0;
        end else begin
            case (m_phase)
                0: if (txn_start) begin
                       m_phase = 1; m_wait = 0; m_rem = int'(txn_len); m_moved = 0;
                       m_read = txn_read; m_spec = txn_special;
                       m_unal = conv_mode && (addr_lo != 2'b00);
                   end
                1: begin
                       m_wait = m_wait + 1;
                       if (devsel) m_phase_eval();
                       else if (m_wait == 5) m_end(m_spec ? 2 : 1);
                   end
                2: m_phase_eval();
                default: begin
                       m_bo = m_bo + 1;
                       if (m_bo == 2) begin e_reis = 1; e_rlen = m_rem; m_phase = 0; end
                   end
            endcase
        end
    end

    function automatic string kind_tag(input int k);
        case (k)
            0: return "R10"; 1: return "R2"; 2: return "R4"; 3: return "R5";
            4: return "R7";  5: return "R6"; 6: return "R9"; default: return "R8";
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s at %0t: actual=%0d expected=%0d", tag, what, $time, act, exp);
        end
    endtask

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            string tg;
            tg = kind_tag(e_valid ? e_kind : int'(term_kind));
            chk(tg, "term_valid", int'(term_valid), e_valid);
            chk({"R12/", tg}, "term_kind", int'(term_kind), e_kind);
            chk({"R5/", tg}, "term_xfer", int'(term_xfer), e_xfer);
            chk({"R5/", tg}, "term_rem", int'(term_rem), e_rem);
            chk("R3", "set_mabort", int'(set_mabort), e_mab);
            chk("R5", "set_tabort", int'(set_tabort), e_tab);
            chk("R3", "cpl_err", int'(cpl_err), e_cpl);
            chk("R6", "reissue_req", int'(reissue_req), e_reis);
            chk("R6", "reissue_len", int'(reissue_len), e_rlen);
            chk("R9", "burst_disc", int'(burst_disc), e_burst);
        end
    end

    task automatic begin_txn(input int len, input bit rd, input bit sp,
                             input logic [1:0] al, input bit cm);
        txn_start = 1'b1; txn_len = LW'(len); txn_read = rd; txn_special = sp;
        addr_lo = al; conv_mode = cm; devsel = 1'b0; trdy = 1'b0; stop = 1'b0;
        @(negedge clk);
        txn_start = 1'b0;
    endtask

    task automatic step(input bit dv, input bit tr, input bit sp);
        devsel = dv; trdy = tr; stop = sp;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL R1 watchdog: actual=timeout expected=finished");
        summary();
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1: reset state at the ports.
        chk("R1", "reset term_valid", int'(term_valid), 0);
        chk("R1", "reset reissue_req", int'(reissue_req), 0);
        chk("R1", "reset status", int'({set_mabort, set_tabort, cpl_err, burst_disc}), 0);
        rst_n = 1'b1;
        idle(2);

        // R10: normal read of three words, claim on second clock.
        begin_txn(3, 1, 0, 2'b00, 1);
        step(0, 0, 0); step(1, 1, 0); step(1, 1, 0); step(1, 1, 0); idle(2);

        // R2 R3: no claim, read master abort.
        begin_txn(2, 1, 0, 2'b00, 1);
        idle(5); idle(2);

        // R2: claim on the fifth clock is still in time.
        begin_txn(2, 0, 0, 2'b00, 1);
        idle(4); step(1, 1, 0); step(1, 1, 0); idle(2);

        // R3: write master abort gives no error completion.
        begin_txn(2, 0, 0, 2'b00, 1);
        idle(5); idle(2);

        // R4: special cycle, empty window, then claimed special cycle.
        begin_txn(1, 0, 1, 2'b00, 1);
        idle(5); idle(2);
        begin_txn(4, 0, 1, 2'b00, 1);
        step(1, 1, 0); idle(2);

        // R5: read target abort after two words.
        begin_txn(5, 1, 0, 2'b00, 1);
        step(1, 1, 0); step(1, 1, 0); step(0, 0, 1); idle(2);

        // R6: disconnect with data, then without data.
        begin_txn(4, 0, 0, 2'b00, 1);
        step(1, 1, 0); step(1, 1, 1); idle(2);
        begin_txn(4, 0, 0, 2'b00, 1);
        step(1, 1, 0); step(1, 0, 1); idle(2);

        // R7 R11: retry, a start during back-off, then a second retry.
        begin_txn(3, 0, 0, 2'b00, 1);
        step(1, 0, 1);
        begin_txn(7, 1, 0, 2'b00, 1);
        step(0, 0, 0);
        chk("R11", "reissue_len after start in back-off", int'(reissue_len), 3);
        chk("R7", "reissue two clocks after retry", int'(reissue_req), 1);
        begin_txn(3, 0, 0, 2'b00, 1);
        step(1, 0, 1); idle(2);
        begin_txn(3, 0, 0, 2'b00, 1);
        step(1, 1, 0); step(1, 1, 0); step(1, 1, 0); idle(2);

        // R8: expiry with grant held has no effect, then grant removed.
        begin_txn(4, 0, 0, 2'b00, 1);
        lat_expired = 1'b1; gnt = 1'b1;
        step(1, 1, 0);
        gnt = 1'b0;
        step(1, 1, 0);
        gnt = 1'b1; lat_expired = 1'b0;
        idle(2);

        // R9: unaligned conventional burst, then unaligned extended mode.
        begin_txn(4, 1, 0, 2'b10, 1);
        step(1, 1, 0); idle(2);
        begin_txn(2, 1, 0, 2'b01, 0);
        step(1, 1, 0); step(1, 1, 0); idle(2);

        // R10: last word with stop, and last word with latency end pending.
        begin_txn(1, 0, 0, 2'b00, 1);
        step(1, 1, 1); idle(2);
        begin_txn(1, 1, 0, 2'b00, 1);
        lat_expired = 1'b1; gnt = 1'b0;
        step(1, 1, 0);
        lat_expired = 1'b0; gnt = 1'b1;
        idle(3);

        summary();
    end
endmodule